// File: doc/BRIEF.md
# CRC-Checked SPI Configuration Register Port

This block is the device side of a serial configuration port. A host reaches an 8-bit register space through SPI mode 0. Every access is a fixed frame of three bytes. The first byte is an instruction: a direction flag and a 7-bit register address. The second byte carries data. The third byte is a CRC-8 check value. The block recomputes the check value over the first two bytes. It commits a write only when the received CRC agrees with its own. It also returns a check byte of its own, so the host can confirm the frame arrived intact.

The SPI pins are oversampled in the system clock domain. The host must keep each SCLK phase at least three system clocks long, and the pins must already be synchronous to `clk`. The serial link has no back-pressure: the host paces every bit, and the block always keeps up. The configuration taps that leave the block are plain level outputs. They have no handshake.

Not every address accepts data, and not every address returns it. Separate read and write address tables govern access. A sticky error flag records any frame whose CRC did not agree.

Top module: `crc_spi_regif`

## Requirements
- R1: The block samples MOSI, MSB first, on SCLK rising edges while CS_N is low, and changes MISO only after SCLK falling edges. A frame is the first 24 sampled bits. Any further bits before CS_N rises are ignored, and MISO stays 0 while they are clocked.
- R2: In the instruction byte, bit 7 = 1 selects a read and bit 7 = 0 selects a write. Bits 6:0 hold the register address.
- R3: The check value is CRC-8 with generator 0x07 and starting value 0xA5. It is processed MSB first over the instruction byte and then the data byte.
- R4: MISO is 0 during the instruction byte. In a read frame, MISO carries the addressed register's value, MSB first, during the data byte. In a write frame, MISO carries 0 during the data byte.
- R5: During the third byte, MISO carries the CRC the block computed over the instruction and data bytes it received. In a read frame with data byte 0x00, this equals the host's CRC.
- R6: A write takes effect only after the 24th bit, and only if the received CRC equals the computed one. Any complete frame with a mismatched CRC, read or write, sets `crc_error`. Only reset clears it.
- R7: Writes land only at addresses 0x00-0x02, 0x0A, 0x0E-0x13 and 0x16-0x3E. A write to any other address changes nothing.
- R8: Reads return stored contents at addresses 0x00-0x07, 0x0A-0x13 and 0x15-0x48. Every other address reads 0x00. Readable addresses that cannot be written also read 0x00.
- R9: If CS_N rises before the 24th bit, the frame is dropped and no write takes place. The next frame starts from bit 0.
- R10: `out_fmt` follows register 0x12 bits 1:0, `sdo_route` follows register 0x10 bit 2, and `single_instr` follows register 0x01 bit 7. These outputs change only when a write is committed.
- R11: After reset, all registers are 0x00, `crc_error` is 0, and MISO is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; oversamples the SPI pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | Serial clock from the host, idle low |
| spi_cs_n | input | 1 | Active-low frame select |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| crc_error | output | 1 | Sticky flag for a CRC mismatch |
| out_fmt | output | 2 | Data output format, from register 0x12[1:0] |
| sdo_route | output | 1 | Route data output onto SDO, from register 0x10[2] |
| single_instr | output | 1 | Single-instruction enable, from register 0x01[7] |

## Verification
Assertions check on every cycle that:
- the bit counter never passes the frame length;
- raising CS_N clears the counter and the transmit shifter;
- the transmit shifter moves only on a falling SCLK;
- the CRC engine sits at its seed while the port is idle;
- the completion pulse occurs only at the 24th bit;
- the error flag, once set, stays set;
- the configuration taps hold still whenever no write is committed.

Only the bench's scenarios can show that the values are right. These cover:
- the bytes on MISO and the CRC returned for each frame;
- which addresses take writes and which read as zero;
- that a write with a bad CRC or an early CS_N rise leaves the register unchanged;
- that bits past the 24th have no effect.

The bench shows these by comparing against a behavioural register model.

// File: rtl/crcspi_pkg.sv
package crcspi_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned ADDR_W = 7;
  localparam int unsigned NUM_REGS = 73;
  localparam logic [BYTE_W-1:0] CRC_POLY = 8'h07;
  localparam logic [BYTE_W-1:0] CRC_SEED = 8'hA5;

  localparam logic [ADDR_W-1:0] ADR_IFB  = 7'h01;
  localparam logic [ADDR_W-1:0] ADR_ROUT = 7'h10;
  localparam logic [ADDR_W-1:0] ADR_FMT  = 7'h12;

  function automatic logic addr_readable(input logic [ADDR_W-1:0] a);
    return (a <= 7'h07) || (a >= 7'h0A && a <= 7'h13) || (a >= 7'h15 && a <= 7'h48);
  endfunction

  function automatic logic addr_writable(input logic [ADDR_W-1:0] a);
    return (a <= 7'h02) || (a == 7'h0A) || (a >= 7'h0E && a <= 7'h13) ||
           (a >= 7'h16 && a <= 7'h3E);
  endfunction
endpackage

// File: rtl/crcspi_crc8.sv
module crcspi_crc8 #(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] POLY = 8'h07,
  parameter logic [W-1:0] SEED = 8'hA5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear_i,
  input  logic         step_i,
  input  logic         bit_i,
  output logic [W-1:0] crc_o
);
  logic [W-1:0] crc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= SEED;
    else if (clear_i) crc_q <= SEED;
    else if (step_i) crc_q <= {crc_q[W-2:0], 1'b0} ^ ((crc_q[W-1] ^ bit_i) ? POLY : '0);
  end

  assign crc_o = crc_q;

  // R3: an idle port keeps the engine at its seed
  a_r3_seed_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (crc_o == SEED));
endmodule

// File: rtl/crcspi_shift.sv
module crcspi_shift #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sclk_i,
  input  logic         cs_n_i,
  input  logic         mosi_i,
  input  logic [W-1:0] rd_byte_i,
  input  logic [W-1:0] crc_byte_i,
  output logic         miso_o,
  output logic         idle_o,
  output logic         bit_stb_o,
  output logic         bit_o,
  output logic [W-1:0] inst_o,
  output logic [W-1:0] data_o,
  output logic [W-1:0] rx_crc_o,
  output logic         done_o
);
  localparam int unsigned FRAME_BITS = 3 * W;
  localparam int unsigned CNT_W = $clog2(FRAME_BITS + 1);
  localparam logic [CNT_W-1:0] END_INST = CNT_W'(W - 1);
  localparam logic [CNT_W-1:0] END_DATA = CNT_W'(2 * W - 1);
  localparam logic [CNT_W-1:0] END_CRC  = CNT_W'(3 * W - 1);
  localparam logic [CNT_W-1:0] LD_DATA  = CNT_W'(W);
  localparam logic [CNT_W-1:0] LD_CRC   = CNT_W'(2 * W);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(FRAME_BITS);

  logic s_sclk, s_cs, s_mosi, sclk_d;
  logic rise, fall;
  logic [CNT_W-1:0] cnt_q;
  logic [W-1:0] rx_sh, tx_q, inst_q, data_q, rxcrc_q;
  logic done_q;
  logic [W-1:0] rx_next;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_sclk <= 1'b0; s_cs <= 1'b1; s_mosi <= 1'b0; sclk_d <= 1'b0;
    end else begin
      s_sclk <= sclk_i; s_cs <= cs_n_i; s_mosi <= mosi_i; sclk_d <= s_sclk;
    end
  end

  assign rise = s_sclk & ~sclk_d & ~s_cs;
  assign fall = ~s_sclk & sclk_d & ~s_cs;
  assign rx_next = {rx_sh[W-2:0], s_mosi};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0; rx_sh <= '0; tx_q <= '0; inst_q <= '0;
      data_q <= '0; rxcrc_q <= '0; done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (s_cs) begin
        cnt_q <= '0;
        tx_q  <= '0;
      end else begin
        if (rise && cnt_q < CNT_MAX) begin
          rx_sh <= rx_next;
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == END_INST) inst_q <= rx_next;
          if (cnt_q == END_DATA) data_q <= rx_next;
          if (cnt_q == END_CRC) begin
            rxcrc_q <= rx_next;
            done_q  <= 1'b1;
          end
        end
        if (fall) begin
          if (cnt_q == LD_DATA) tx_q <= rd_byte_i;
          else if (cnt_q == LD_CRC) tx_q <= crc_byte_i;
          else tx_q <= {tx_q[W-2:0], 1'b0};
        end
      end
    end
  end

  assign miso_o    = tx_q[W-1];
  assign idle_o    = s_cs;
  assign bit_stb_o = rise && (cnt_q < LD_CRC);
  assign bit_o     = s_mosi;
  assign inst_o    = inst_q;
  assign data_o    = data_q;
  assign rx_crc_o  = rxcrc_q;
  assign done_o    = done_q;

  // R9: a raised select clears the frame position and the transmit shifter
  a_r9_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
    s_cs |=> (cnt_q == '0 && tx_q == '0));
  // R1: the bit position never runs past the frame length
  a_r1_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_MAX);
  // R1: outgoing data moves only on a falling SCLK
  a_r1_tx_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (!fall && !s_cs) |=> $stable(tx_q));
  // R6: completion is flagged only once the last bit is in
  a_r6_done_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (cnt_q == CNT_MAX));
endmodule

// File: rtl/crcspi_regs.sv
module crcspi_regs
  import crcspi_pkg::*;
#(
  parameter int unsigned W = BYTE_W,
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned NREG = NUM_REGS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [W-1:0]  wr_data_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [W-1:0]  rd_data_o,
  output logic [1:0]    fmt_sel_o,
  output logic          sdo_route_o,
  output logic          single_instr_o
);
  logic [W-1:0] store [NREG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int a = 0; a < NREG; a++) store[a] <= '0;
    end else if (wr_en_i) begin
      for (int a = 0; a < NREG; a++)
        if (wr_addr_i == AW'(a) && addr_writable(AW'(a))) store[a] <= wr_data_i;
    end
  end

  always_comb begin
    rd_data_o = '0;
    for (int a = 0; a < NREG; a++)
      if (rd_addr_i == AW'(a) && addr_readable(AW'(a))) rd_data_o = store[a];
  end

  assign fmt_sel_o      = store[ADR_FMT][1:0];
  assign sdo_route_o    = store[ADR_ROUT][2];
  assign single_instr_o = store[ADR_IFB][7];

  // R10: configuration taps move only on a committed write
  a_r10_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_i |=> $stable({fmt_sel_o, sdo_route_o, single_instr_o}));
endmodule

// File: rtl/crc_spi_regif.sv
module crc_spi_regif
  import crcspi_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       spi_sclk,
  input  logic       spi_cs_n,
  input  logic       spi_mosi,
  output logic       spi_miso,
  output logic       crc_error,
  output logic [1:0] out_fmt,
  output logic       sdo_route,
  output logic       single_instr
);
  logic idle, bit_stb, bit_v, done;
  logic [BYTE_W-1:0] inst, data, rx_crc, crc_val, rd_data, rd_byte;
  logic crc_ok, wr_en, err_q;

  crcspi_shift #(.W(BYTE_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .sclk_i(spi_sclk), .cs_n_i(spi_cs_n), .mosi_i(spi_mosi),
    .rd_byte_i(rd_byte), .crc_byte_i(crc_val), .miso_o(spi_miso), .idle_o(idle),
    .bit_stb_o(bit_stb), .bit_o(bit_v), .inst_o(inst), .data_o(data),
    .rx_crc_o(rx_crc), .done_o(done)
  );

  crcspi_crc8 #(.W(BYTE_W), .POLY(CRC_POLY), .SEED(CRC_SEED)) u_crc (
    .clk(clk), .rst_n(rst_n), .clear_i(idle), .step_i(bit_stb), .bit_i(bit_v),
    .crc_o(crc_val)
  );

  crcspi_regs #(.W(BYTE_W), .AW(ADDR_W), .NREG(NUM_REGS)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_addr_i(inst[ADDR_W-1:0]),
    .wr_data_i(data), .rd_addr_i(inst[ADDR_W-1:0]), .rd_data_o(rd_data),
    .fmt_sel_o(out_fmt), .sdo_route_o(sdo_route), .single_instr_o(single_instr)
  );

  assign rd_byte = inst[BYTE_W-1] ? rd_data : '0;
  assign crc_ok  = (rx_crc == crc_val);
  assign wr_en   = done && !inst[BYTE_W-1] && crc_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else if (done && !crc_ok) err_q <= 1'b1;
  end

  assign crc_error = err_q;

  // R6: the mismatch flag is sticky
  a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    crc_error |=> crc_error);
  // R6: the flag rises only after a completed frame
  a_r6_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(crc_error) |-> $past(done));
endmodule

// File: tb/crc_spi_regif_tb_top.sv
`timescale 1ns/1ps
module crc_spi_regif_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic spi_sclk = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
  logic spi_miso, crc_error, sdo_route, single_instr;
  logic [1:0] out_fmt;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [7:0] mem [128];
  bit exp_err = 0;

  always #2.5 clk = ~clk;

  crc_spi_regif dut_i (
    .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .crc_error(crc_error),
    .out_fmt(out_fmt), .sdo_route(sdo_route), .single_instr(single_instr)
  );

  function automatic logic [7:0] host_crc(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] c;
    logic [15:0] m;
    logic fb;
    c = 8'hA5;
    m = {a, b};
    for (int i = 15; i >= 0; i--) begin
      fb = c[7] ^ m[i];
      c = {c[6:0], 1'b0};
      if (fb) c = c ^ 8'h07;
    end
    return c;
  endfunction

  function automatic bit may_write(input int a);
    return (a <= 2) || (a == 10) || (a >= 14 && a <= 19) || (a >= 22 && a <= 62);
  endfunction

  function automatic bit may_read(input int a);
    return (a <= 7) || (a >= 10 && a <= 19) || (a >= 21 && a <= 72);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // per-clock comparison against the model while the port is idle (R10, R6)
  always @(negedge clk) begin
    if (rst_n && spi_cs_n && !finished) begin
      check(out_fmt == mem[8'h12][1:0], "R10 out_fmt", out_fmt, mem[8'h12][1:0]);
      check(sdo_route == mem[8'h10][2], "R10 sdo_route", sdo_route, mem[8'h10][2]);
      check(single_instr == mem[8'h01][7], "R10 single_instr", single_instr, mem[8'h01][7]);
      check(crc_error == exp_err, "R6 crc_error", crc_error, exp_err);
    end
  end

  task automatic run_frame(input logic [7:0] i0, input logic [7:0] d1, input logic [7:0] c2,
                           input int nbits, output logic [7:0] o0, output logic [7:0] o1,
                           output logic [7:0] o2);
    logic [31:0] word;
    logic [31:0] got;
    logic [7:0] calc;
    word = {i0, d1, c2, 8'h00};
    got = '0;
    @(negedge clk); spi_cs_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int b = 0; b < nbits; b++) begin
      spi_mosi = word[31-b];
      repeat (4) @(negedge clk);
      got[31-b] = spi_miso;
      spi_sclk = 1'b1;
      repeat (4) @(negedge clk);
      spi_sclk = 1'b0;
    end
    repeat (4) @(negedge clk);
    if (nbits >= 24) begin
      calc = host_crc(i0, d1);
      if (c2 != calc) exp_err = 1;
      else if (!i0[7] && may_write(int'(i0[6:0]))) mem[i0[6:0]] = d1;
    end
    spi_cs_n = 1'b1;
    spi_mosi = 1'b0;
    repeat (6) @(negedge clk);
    o0 = got[31:24]; o1 = got[23:16]; o2 = got[15:8];
  endtask

  task automatic do_write(input logic [6:0] a, input logic [7:0] d);
    logic [7:0] x0, x1, x2;
    run_frame({1'b0, a}, d, host_crc({1'b0, a}, d), 24, x0, x1, x2);
  endtask

  task automatic read_check(input logic [6:0] a, input string req);
    logic [7:0] x0, x1, x2, exp;
    exp = may_read(int'(a)) ? mem[a] : 8'h00;
    run_frame({1'b1, a}, 8'h00, host_crc({1'b1, a}, 8'h00), 24, x0, x1, x2);
    check(x1 == exp, req, x1, exp);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] r0, r1, r2;
    for (int a = 0; a < 128; a++) mem[a] = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R11 reset state
    check(crc_error == 1'b0, "R11 crc_error", crc_error, 0);
    check(spi_miso == 1'b0, "R11 miso", spi_miso, 0);
    check({out_fmt, sdo_route, single_instr} == 4'h0, "R11 cfg", {out_fmt, sdo_route, single_instr}, 0);

    // R2 R4 R5 R3: scratch write then read with CRC echo
    run_frame(8'h0A, 8'h5C, host_crc(8'h0A, 8'h5C), 24, r0, r1, r2);
    check(r1 == 8'h00, "R4 write-frame data byte", r1, 0);
    check(r2 == host_crc(8'h0A, 8'h5C), "R5 write-frame crc byte", r2, host_crc(8'h0A, 8'h5C));
    run_frame(8'h8A, 8'h00, host_crc(8'h8A, 8'h00), 24, r0, r1, r2);
    check(r0 == 8'h00, "R4 instruction byte miso", r0, 0);
    check(r1 == 8'h5C, "R4 read data", r1, 8'h5C);
    check(r2 == host_crc(8'h8A, 8'h00), "R5 R3 crc echo", r2, host_crc(8'h8A, 8'h00));

    // R10 configuration taps
    do_write(7'h12, 8'hF3);
    do_write(7'h10, 8'h04);
    do_write(7'h01, 8'h80);
    check(out_fmt == 2'b11, "R10 fmt", out_fmt, 3);
    check(sdo_route && single_instr, "R10 route/single", {sdo_route, single_instr}, 3);
    read_check(7'h12, "R10 readback 0x12");

    // R7 write table boundaries
    do_write(7'h3E, 8'h77); read_check(7'h3E, "R7 0x3E writable");
    do_write(7'h3F, 8'h66); read_check(7'h3F, "R7 0x3F ignored");
    do_write(7'h16, 8'h21); read_check(7'h16, "R7 0x16 writable");
    do_write(7'h15, 8'h99); read_check(7'h15, "R7 0x15 ignored");
    do_write(7'h07, 8'hFF); read_check(7'h07, "R7 0x07 ignored");
    do_write(7'h02, 8'h3A); read_check(7'h02, "R7 0x02 writable");
    do_write(7'h03, 8'h3B); read_check(7'h03, "R7 0x03 ignored");

    // R8 unreadable addresses
    do_write(7'h14, 8'h55); read_check(7'h14, "R8 0x14 zero");
    read_check(7'h08, "R8 0x08 zero");
    read_check(7'h49, "R8 0x49 zero");
    read_check(7'h7F, "R8 0x7F zero");

    // R9 aborted frame, then an immediate full frame
    run_frame(8'h0A, 8'hEE, host_crc(8'h0A, 8'hEE), 20, r0, r1, r2);
    read_check(7'h0A, "R9 abort leaves 0x0A");
    run_frame(8'h0A, 8'h3C, host_crc(8'h0A, 8'h3C), 5, r0, r1, r2);
    do_write(7'h0A, 8'hC3);
    read_check(7'h0A, "R9 next frame from bit 0");

    // R1 bits past the 24th ignored
    run_frame(8'h20, 8'h3C, host_crc(8'h20, 8'h3C), 32, r0, r1, r2);
    read_check(7'h20, "R1 trailing bits");

    // R6 read with bad CRC still returns data and sets the flag
    check(crc_error == 1'b0, "R6 flag clear before", crc_error, 0);
    run_frame(8'h8A, 8'h00, 8'h00 ^ host_crc(8'h8A, 8'h00) ^ 8'h01, 24, r0, r1, r2);
    check(r1 == 8'hC3, "R6 bad-crc read data", r1, 8'hC3);
    check(crc_error == 1'b1, "R6 flag set", crc_error, 1);
    // R6 write with bad CRC not committed
    run_frame(8'h0A, 8'h11, host_crc(8'h0A, 8'h11) ^ 8'h80, 24, r0, r1, r2);
    read_check(7'h0A, "R6 bad-crc write dropped");
    run_frame(8'h12, 8'h00, host_crc(8'h12, 8'h00) ^ 8'h02, 24, r0, r1, r2);
    check(out_fmt == 2'b11, "R6 R10 fmt unchanged", out_fmt, 3);
    check(crc_error == 1'b1, "R6 flag sticky", crc_error, 1);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule